// File: doc/BRIEF.md
# I2C Slave Address-Phase Matcher

This block handles the address phase of an I2C slave. It watches the SCL and SDA lines, which are already synchronised to the system clock, and detects START, repeated START and STOP. After a START it shifts in the first byte on rising SCL edges: seven address bits, then the read/write bit. It then compares that byte with a programmable own address. On the falling edge of the eighth SCL clock it posts the result to a status word and pulses an interrupt line.

Besides ordinary 7-bit matches, the block detects reserved extension-code prefixes, where the upper four bits are all zeros or all ones. It reports these on a separate flag, because a slave that sees one stays engaged in the transfer even when its address differs. A first byte that matches a 10-bit own-address prefix sets the extension flag and the match flag together. The general call byte gets its own flag.

Software can issue a release pulse at any time. The release drops the slave back to idle at once, and the block then ignores the bus until it sees a fresh START. Data bytes, acknowledge driving and clock stretching are handled elsewhere. No data stream crosses this block's edge, so every pin is a plain control or status signal and there is no valid/ready handshake or back-pressure.

Top module: `i2c_slave_addr_match`

## Requirements
- R1: After reset `status_o` is 0x00 and `irq_o` is 0. Status bits 7, 6 and 0 always read 0.
- R2: A START or repeated START (SDA falls while SCL is high) clears status bits 5..1 and starts a new address byte. A STOP (SDA rises while SCL is high) clears status bits 5..1 and returns the block to idle.
- R3: If the received 7 address bits equal `own_addr_i[7:1]` and the own address is not a 10-bit prefix (`own_addr_i[7:3]` is not 11110), the following happens regardless of the R/W bit:
  - status bit 4 (match) is set;
  - status bit 2 takes the received R/W value;
  - status bit 1 (engaged) is set;
  - `irq_o` pulses high for exactly one cycle.
- R4: A first byte with no address match and no extension prefix leaves the status at 0x00 and raises no interrupt.
- R5: If the upper four bits of the received byte are 0000 or 1111, status bit 5 (extension) and bit 1 (engaged) are set and `irq_o` pulses. This happens even when the address does not match.
- R6: The first byte 0x00 (general call) sets status bit 3 together with bits 5 and 1.
- R7: If `own_addr_i` holds 11110xx0 and the received first byte equals it, status bits 5 and 4 are both set.
- R8: A first byte 11110xx1 that matches the own prefix sets bit 4 only if a matching 10-bit write first byte was received earlier with no STOP or release in between. Otherwise only bit 5 is set.
- R9: A release pulse clears status bits 5..1 on the next clock. After it, SCL clocking without a START sets no flags and raises no interrupt. A later START restores normal matching.
- R10: A release in the same cycle as the eighth SCL falling edge wins: no interrupt is raised and the status stays 0x00.
- R11: Before the eighth SCL falling edge of the address byte, `irq_o` stays 0 and the status bits stay 0. The interrupt and flags appear in the clock cycle after that falling edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| own_addr_i | input | 8 | Own address in bits 7..1; bit 0 unused |
| release_i | input | 1 | One-cycle release command |
| irq_o | output | 1 | One-cycle address-phase interrupt |
| status_o | output | 8 | Bit 5 extension, 4 match, 3 general call, 2 R/W, 1 engaged |

## Verification
The release command and the eighth SCL falling edge can land in the same clock cycle. In that case the block must choose between posting the address result and dropping to idle. The bench provokes this by lowering SCL for the last address bit on the same cycle that it raises the release pulse. It judges the outcome by an absent interrupt and a zero status, both in that cycle and in the next. A second pairing is tested as well: the extension and match flags that a 10-bit first byte sets together. These are checked both with and without an earlier write match.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_HELD} phase_t;

  localparam int ST_EXT   = 5;
  localparam int ST_MATCH = 4;
  localparam int ST_GCALL = 3;
  localparam int ST_RW    = 2;
  localparam int ST_ENG   = 1;

  typedef struct packed {
    logic ext;
    logic match;
    logic gcall;
    logic tenbit_wr;
  } verdict_t;
endpackage

// File: rtl/i2c_am_line_watch.sv
module i2c_am_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise = scl_i & ~scl_q;
    scl_fall = ~scl_i & scl_q;
    start_c  = scl_i & scl_q & sda_q & ~sda_i;
    stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] data,
  output logic              full
);
  localparam int CW = $clog2(BYTE_W + 1);
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      count <= '0;
    end else if (clear) begin
      data  <= '0;
      count <= '0;
    end else if (shift_en && !full) begin
      data  <= {data[BYTE_W-2:0], bit_in};
      count <= count + 1'b1;
    end
  end

  assign full = (count == CW'(BYTE_W));
endmodule

// File: rtl/i2c_am_decode.sv
module i2c_am_decode
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0] rx_byte,
  input  logic [ADDR_W:0] own_addr,
  input  logic            armed,
  output verdict_t        verdict
);
  localparam int TOP = ADDR_W;
  logic [3:0] nib;
  logic       addr_eq, tenbit_own;

  always_comb begin
    nib        = rx_byte[TOP -: 4];
    addr_eq    = (rx_byte[TOP:1] == own_addr[TOP:1]);
    tenbit_own = (own_addr[TOP -: 5] == 5'b11110);
    verdict.ext       = (nib == 4'h0) || (nib == 4'hF);
    verdict.gcall     = (rx_byte == '0);
    verdict.match     = addr_eq && (!tenbit_own || !rx_byte[0] || armed);
    verdict.tenbit_wr = addr_eq && tenbit_own && !rx_byte[0];
  end
endmodule

// File: rtl/i2c_slave_addr_match.sv
module i2c_slave_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W:0]   own_addr_i,
  input  logic              release_i,
  output logic              irq_o,
  output logic [7:0]        status_o
);
  localparam int BYTE_W = ADDR_W + 1;

  logic scl_rise, scl_fall, start_c, stop_c;
  logic [BYTE_W-1:0] rx_byte;
  logic full, eighth_fall;
  phase_t phase;
  verdict_t verdict;
  logic armed, f_ext, f_match, f_gcall, f_rw, f_eng;

  i2c_am_line_watch u_watch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  i2c_am_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(start_c),
    .shift_en(phase == PH_ADDR && scl_rise),
    .bit_in(sda_i), .data(rx_byte), .full(full)
  );

  i2c_am_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rx_byte(rx_byte), .own_addr(own_addr_i), .armed(armed), .verdict(verdict)
  );

  assign eighth_fall = (phase == PH_ADDR) && full && scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      {f_ext, f_match, f_gcall, f_rw, f_eng} <= '0;
      armed <= 1'b0;
      irq_o <= 1'b0;
    end else if (release_i || stop_c) begin
      phase <= PH_IDLE;
      {f_ext, f_match, f_gcall, f_rw, f_eng} <= '0;
      armed <= 1'b0;
      irq_o <= 1'b0;
    end else if (start_c) begin
      phase <= PH_ADDR;
      {f_ext, f_match, f_gcall, f_rw, f_eng} <= '0;
      irq_o <= 1'b0;
    end else if (eighth_fall) begin
      phase   <= PH_HELD;
      f_ext   <= verdict.ext;
      f_match <= verdict.match;
      f_gcall <= verdict.gcall;
      f_rw    <= (verdict.ext || verdict.match) ? rx_byte[0] : 1'b0;
      f_eng   <= verdict.ext || verdict.match;
      irq_o   <= verdict.ext || verdict.match;
      armed   <= armed || verdict.tenbit_wr;
    end else begin
      irq_o <= 1'b0;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_EXT]   = f_ext;
    status_o[ST_MATCH] = f_match;
    status_o[ST_GCALL] = f_gcall;
    status_o[ST_RW]    = f_rw;
    status_o[ST_ENG]   = f_eng;
  end
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       release_i,
  input logic       irq_o,
  input logic [7:0] status_o
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7:6] == 2'b00 && status_o[0] == 1'b0);
  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R11
  irq_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(scl_i, 2) && !$past(scl_i)));
  // R5
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o[5] || status_o[4]));
  // R6
  gcall_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[3] |-> status_o[5]);
  // R9
  release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(release_i) |-> (!irq_o && status_o == 8'h00));
endmodule

bind i2c_slave_addr_match i2c_am_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .release_i(release_i),
  .irq_o(irq_o), .status_o(status_o)
);

// File: tb/tb_i2c_slave_addr_match.sv
module tb_i2c_slave_addr_match;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, scl = 1, sda = 1, rel = 0;
  logic [7:0] own = 8'hA4;
  logic irq;
  logic [7:0] status;
  int n_chk = 0, n_bad = 0;
  logic last_irq, last_irq2;
  logic [7:0] last_st;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slave_addr_match dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .own_addr_i(own), .release_i(rel), .irq_o(irq), .status_o(status)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    @(negedge clk) sda = 1; tick(2);
    scl = 1; tick(2);
    sda = 0; tick(2);
    scl = 0; tick(2);
  endtask

  task automatic bus_stop;
    @(negedge clk) sda = 0; tick(2);
    scl = 1; tick(2);
    sda = 1; tick(2);
  endtask

  // Clocks one byte; the 8th fall optionally coincides with release.
  task automatic send_byte(input logic [7:0] b, input logic rel_end);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) sda = b[i]; tick(2);
      scl = 1; tick(3);
      if (i > 0) begin
        scl = 0; tick(2);
      end
    end
    check({7'b0, irq}, 8'h00, "R11 irq before 8th fall");
    check(status, 8'h00, "R11 status before 8th fall");
    scl = 0; rel = rel_end;
    @(posedge clk); #1;
    last_irq = irq; last_st = status;
    @(negedge clk) rel = 0;
    @(posedge clk); #1;
    last_irq2 = irq;
    tick(2);
  endtask

  task automatic t_reset;
    check(status, 8'h00, "R1 reset status");
    check({7'b0, irq}, 8'h00, "R1 reset irq");
  endtask

  task automatic t_plain_match;
    own = 8'hA4;
    bus_start;
    send_byte(8'hA5, 0);
    check({7'b0, last_irq}, 8'h01, "R3 irq on match");
    check({7'b0, last_irq2}, 8'h00, "R3 irq one cycle");
    check(last_st, 8'h16, "R3 match+rw+engaged");
    bus_stop;
    check(status, 8'h00, "R2 stop clears");
  endtask

  task automatic t_miss;
    bus_start;
    send_byte(8'hB6, 0);
    check({7'b0, last_irq}, 8'h00, "R4 no irq on miss");
    check(last_st, 8'h00, "R4 no flags on miss");
    bus_stop;
  endtask

  task automatic t_ext;
    bus_start;
    send_byte(8'hF0, 0);
    check({7'b0, last_irq}, 8'h01, "R5 irq on 1111 prefix");
    check(last_st, 8'h22, "R5 ext 1111 write");
    bus_start;
    check(status, 8'h00, "R2 repeated start clears");
    send_byte(8'h07, 0);
    check(last_st, 8'h26, "R5 ext 0000 read");
    bus_stop;
  endtask

  task automatic t_gcall;
    bus_start;
    send_byte(8'h00, 0);
    check({7'b0, last_irq}, 8'h01, "R6 irq on general call");
    check(last_st, 8'h2A, "R6 general call flags");
    bus_stop;
  endtask

  task automatic t_tenbit;
    own = 8'hF2;
    bus_start;
    send_byte(8'hF2, 0);
    check(last_st, 8'h32, "R7 10-bit write ext+match");
    bus_start;
    send_byte(8'hF3, 0);
    check(last_st, 8'h36, "R8 armed 10-bit read matches");
    bus_stop;
    bus_start;
    send_byte(8'hF3, 0);
    check(last_st, 8'h26, "R8 unarmed 10-bit read ext only");
    bus_stop;
    own = 8'hA4;
  endtask

  task automatic t_release;
    bus_start;
    send_byte(8'hA4, 0);
    check(last_st, 8'h12, "R9 match before release");
    @(negedge clk) rel = 1;
    @(posedge clk); #1;
    check(status, 8'h00, "R9 release clears at once");
    @(negedge clk) rel = 0;
    send_byte(8'hA4, 0);
    check({7'b0, last_irq}, 8'h00, "R9 bus ignored after release irq");
    check(last_st, 8'h00, "R9 bus ignored after release status");
    bus_start;
    send_byte(8'hA4, 0);
    check(last_st, 8'h12, "R9 match after fresh start");
    bus_stop;
  endtask

  task automatic t_collide;
    bus_start;
    send_byte(8'hA4, 1);
    check({7'b0, last_irq}, 8'h00, "R10 release beats 8th fall irq");
    check(last_st, 8'h00, "R10 release beats 8th fall status");
    check({7'b0, last_irq2}, 8'h00, "R10 no late irq");
    bus_stop;
  endtask

  initial begin
    tick(3);
    #1 t_reset;
    rst_n = 1;
    tick(3);
    t_reset;
    t_plain_match;
    t_miss;
    t_ext;
    t_gcall;
    t_tenbit;
    t_release;
    t_collide;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule